// File: doc/BRIEF.md
# Flattened Loop-Nest Multiply-Accumulator

This block walks a two-level loop nest, outer index `i` and inner index `j`, as a single flattened sequence with `j` stepping fastest. A new iteration enters every clock cycle. Each iteration reads array element `A[i]` from an external single-port memory, multiplies it by the inner index `j` on the one shared multiplier, and adds the product to a signed accumulator. With the default 20 by 20 nest a run is 400 iterations, followed by a short fill and drain.

A one-cycle `start` pulse begins a run. The engine drives the memory address and read strobe, lines the inner index up with the data the memory returns one cycle later, and raises `done` for one cycle once the last product has been added. The accumulator is not cleared when a run starts, so each run adds its total to the value left by earlier runs. Only reset clears it.

Top module: `loopnest_mac`

## Requirements
- R1: After synchronous reset, `result` is 0 and `busy`, `done` and `mem_rd` are 0.
- R2: During a run, `mem_addr` holds outer index `i` for INNER_N consecutive cycles, starting at 0 in the cycle after the start edge and stepping by one each time `j` wraps, up to OUTER_N-1.
- R3: `done` is high in the cycle after the (OUTER_N*INNER_N + RD_LAT + 1)-th rising edge that follows the edge sampling an accepted `start`. With the defaults that is edge 402.
- R4: At `done`, `result` equals the previous `result` plus the sum over all (i, j) of A[i]*j. A[i] is a signed DATA_W-bit value, j is unsigned, and each product is formed at full 2*DATA_W width.
- R5: A new run does not clear the accumulator. Back-to-back runs keep adding to the same total.
- R6: A `start` pulse while `busy` is high, including during the drain after the last read, has no effect. The run's timing, its single `done` and its `result` stay unchanged.
- R7: `done` lasts exactly one cycle. `busy` is low in that cycle, so a `start` in the `done` cycle is accepted.
- R8: The accumulator wraps modulo 2^ACC_W as two's complement. When ACC_W is narrower than a product, the product is truncated to ACC_W bits before it is added.
- R9: `mem_rd` is high for exactly OUTER_N*INNER_N cycles per run, one read per iteration, and these are the same cycles in which R2 defines `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts a run while idle |
| mem_rd | output | 1 | Read strobe, one per iteration |
| mem_addr | output | AW | Array index `i` |
| mem_data | input | DATA_W | Signed element, returned RD_LAT cycles after the address |
| busy | output | 1 | Run in progress, from start until the done cycle |
| done | output | 1 | One-cycle pulse once the final product has been added |
| result | output | ACC_W | Signed accumulator |

## Verification
The checks inside the design assume that the memory returns the element for each address exactly RD_LAT cycles later and that `start` is a clean synchronous level. The bench models the memory as a registered array with a one-cycle read, drives `start` only on falling edges, and deliberately pulses it mid-run and during the drain. It sweeps several element patterns: all zeros, the positive and negative extremes, a ramp and an alternating sign pattern. It uses a 20-bit accumulator so that wrap-around occurs within a single run.

// File: rtl/loopnest_pkg.sv
package loopnest_pkg;
   // bit width able to hold values 0 .. n-1
   function automatic int cnt_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
   // sum of 0 .. n-1
   function automatic longint tri_sum(input int n);
      return longint'(n) * longint'(n - 1) / 2;
   endfunction
endpackage

// File: rtl/loopnest_idx.sv
module loopnest_idx #(
   parameter int OUTER_N = 20,
   parameter int INNER_N = 20,
   parameter int AW      = 5,
   parameter int JW      = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          fire,
   output logic          issue,
   output logic [AW-1:0] addr,
   output logic [JW-1:0] jidx,
   output logic          last
);
   localparam logic [AW-1:0] I_MAX = AW'(OUTER_N - 1);
   localparam logic [JW-1:0] J_MAX = JW'(INNER_N - 1);

   logic [AW-1:0] i_q;
   logic [JW-1:0] j_q;
   logic          run_q;
   logic          j_wrap;

   assign j_wrap = (j_q == J_MAX);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         i_q   <= '0;
         j_q   <= '0;
      end else if (fire) begin
         run_q <= 1'b1;
         i_q   <= '0;
         j_q   <= '0;
      end else if (run_q) begin
         if (j_wrap) begin
            j_q <= '0;
            if (i_q == I_MAX) begin
               run_q <= 1'b0;
               i_q   <= '0;
            end else begin
               i_q <= i_q + 1'b1;
            end
         end else begin
            j_q <= j_q + 1'b1;
         end
      end
   end

   assign issue = run_q;
   assign addr  = i_q;
   assign jidx  = j_q;
   assign last  = run_q && j_wrap && (i_q == I_MAX);

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      issue && !j_wrap && !fire |=> $stable(addr));
   // R2
   addr_first_chk: assert property (@(posedge clk) disable iff (rst)
      fire |=> (addr == '0) && issue);
   // R9
   read_end_chk: assert property (@(posedge clk) disable iff (rst)
      last && !fire |=> !issue);
endmodule

// File: rtl/loopnest_align.sv
module loopnest_align #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (DEPTH < 0) begin : g_bad_depth
      $error("loopnest_align: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_pass
      assign dout = din;
   end else begin : g_pipe
      logic [WIDTH-1:0] stage_q [DEPTH];
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= din;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
         end
      end
      assign dout = stage_q[DEPTH-1];
   end
endmodule

// File: rtl/loopnest_dp.sv
module loopnest_dp #(
   parameter int DATA_W = 12,
   parameter int JW     = 5,
   parameter int ACC_W  = 32
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_v,
   input  logic                     in_last,
   input  logic [JW-1:0]            in_j,
   input  logic signed [DATA_W-1:0] in_data,
   output logic signed [ACC_W-1:0]  acc,
   output logic                     fin
);
   localparam int PW = 2 * DATA_W;

   logic signed [PW-1:0]    prod_q;
   logic                    prod_v;
   logic                    prod_last;
   logic signed [PW-1:0]    prod_c;
   logic signed [ACC_W-1:0] addend;

   assign prod_c = PW'(in_data * $signed({1'b0, in_j}));

   always_ff @(posedge clk) begin
      if (rst) begin
         prod_q    <= '0;
         prod_v    <= 1'b0;
         prod_last <= 1'b0;
      end else begin
         prod_q    <= in_v ? prod_c : '0;
         prod_v    <= in_v;
         prod_last <= in_v && in_last;
      end
   end

   if (ACC_W >= PW) begin : g_extend
      assign addend = ACC_W'(prod_q);
   end else begin : g_trunc
      assign addend = prod_q[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc <= '0;
         fin <= 1'b0;
      end else begin
         if (prod_v) acc <= acc + addend;
         fin <= prod_v && prod_last;
      end
   end

   // R4
   acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !prod_v |=> $stable(acc));
   // R7
   fin_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      fin |=> !fin);
endmodule

// File: rtl/loopnest_mac.sv
module loopnest_mac #(
   parameter int OUTER_N = 20,
   parameter int INNER_N = 20,
   parameter int DATA_W  = 12,
   parameter int ACC_W   = 32,
   parameter int RD_LAT  = 1,
   localparam int AW     = loopnest_pkg::cnt_w(OUTER_N)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   output logic                     mem_rd,
   output logic [AW-1:0]            mem_addr,
   input  logic signed [DATA_W-1:0] mem_data,
   output logic                     busy,
   output logic                     done,
   output logic signed [ACC_W-1:0]  result
);
   localparam int JW = loopnest_pkg::cnt_w(INNER_N);
   localparam int SW = JW + 2;

   if (OUTER_N < 1 || INNER_N < 1) begin : g_bad_n
      $error("loopnest_mac: loop bounds must be positive");
   end
   if (JW + 1 > DATA_W) begin : g_bad_j
      $error("loopnest_mac: inner index does not fit the multiplier width");
   end
   if (RD_LAT < 0) begin : g_bad_lat
      $error("loopnest_mac: RD_LAT must not be negative");
   end

   logic          busy_q;
   logic          fire;
   logic          issue;
   logic          last;
   logic [JW-1:0] jidx;
   logic [SW-1:0] side_in;
   logic [SW-1:0] side_out;
   logic          fin;

   assign fire = start && !busy_q;

   loopnest_idx #(.OUTER_N(OUTER_N), .INNER_N(INNER_N), .AW(AW), .JW(JW)) u_idx (
      .clk(clk), .rst(rst), .fire(fire),
      .issue(issue), .addr(mem_addr), .jidx(jidx), .last(last)
   );

   assign side_in = {issue, last, jidx};

   loopnest_align #(.WIDTH(SW), .DEPTH(RD_LAT)) u_align (
      .clk(clk), .rst(rst), .din(side_in), .dout(side_out)
   );

   loopnest_dp #(.DATA_W(DATA_W), .JW(JW), .ACC_W(ACC_W)) u_dp (
      .clk(clk), .rst(rst),
      .in_v(side_out[SW-1]), .in_last(side_out[SW-2]), .in_j(side_out[JW-1:0]),
      .in_data(mem_data), .acc(result), .fin(fin)
   );

   always_ff @(posedge clk) begin
      if (rst) busy_q <= 1'b0;
      else if (fire) busy_q <= 1'b1;
      else if (u_dp.prod_v && u_dp.prod_last) busy_q <= 1'b0;
   end

   assign busy   = busy_q;
   assign done   = fin;
   assign mem_rd = issue;

   // R6
   start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      busy_q && start && !(u_dp.prod_v && u_dp.prod_last) |=> busy_q && !(issue && mem_addr == '0 && jidx == '0 && $rose(issue)));
   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
   // R5
   result_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !busy && !start |=> $stable(result));
   // R9
   read_in_run_chk: assert property (@(posedge clk) disable iff (rst)
      mem_rd |-> busy);
endmodule

// File: tb/loopnest_mac_test.sv
module loopnest_mac_test;
   localparam int ON  = 20;
   localparam int IN  = 20;
   localparam int DW  = 12;
   localparam int AW_ = 20;
   localparam int DONE_K = ON * IN + 1 + 1;

   logic clk = 1'b0;
   logic rst;
   logic start;
   logic mem_rd;
   logic [4:0] mem_addr;
   logic signed [DW-1:0] mem_data;
   logic busy;
   logic done;
   logic signed [AW_-1:0] result;

   logic signed [DW-1:0] arr [ON];
   logic [AW_-1:0] exp_acc;
   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   always_ff @(posedge clk) mem_data <= arr[(mem_addr < 5'(ON)) ? mem_addr : 5'd0];

   loopnest_mac #(.OUTER_N(ON), .INNER_N(IN), .DATA_W(DW), .ACC_W(AW_), .RD_LAT(1)) uut (
      .clk(clk), .rst(rst), .start(start), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_data(mem_data), .busy(busy), .done(done), .result(result)
   );

   task automatic check(input string req, input longint act, input longint expv);
      tests++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // one run; stray1/stray2 are cycles at which an extra start pulse is driven
   task automatic run_one(input string tag, input int stray1, input int stray2);
      longint tot = 0;
      int addr_bad = 0;
      int rd_cnt = 0;
      int done_cnt = 0;
      int done_k = -1;
      int busy_at_done = -1;
      for (int i = 0; i < ON; i++) tot += longint'(arr[i]) * longint'(IN * (IN - 1) / 2);
      exp_acc = exp_acc + AW_'(tot);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int k = 0; k < DONE_K + 6; k++) begin
         if (k < ON * IN) begin
            if (mem_addr != 5'(k / IN) || !mem_rd) addr_bad++;
         end
         if (mem_rd) rd_cnt++;
         if (done) begin
            done_cnt++;
            done_k = k;
            busy_at_done = busy;
         end
         start = (k == stray1 || k == stray2);
         @(negedge clk);
         start = 1'b0;
      end
      check({tag, " R2 address mismatches"}, addr_bad, 0);
      check({tag, " R9 read count"}, rd_cnt, ON * IN);
      check({tag, " R3 done cycle"}, done_k, DONE_K);
      check({tag, " R7 done count"}, done_cnt, 1);
      check({tag, " R7 busy in done cycle"}, busy_at_done, 0);
      check({tag, " R4 result"}, longint'(result), longint'($signed(exp_acc)));
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      rst = 1'b1;
      start = 1'b0;
      exp_acc = '0;
      for (int i = 0; i < ON; i++) arr[i] = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1
      check("R1 result after reset", result, 0);
      check("R1 busy after reset", busy, 0);
      check("R1 done after reset", done, 0);
      check("R1 read after reset", mem_rd, 0);

      run_one("zeros R4", -1, -1);
      for (int i = 0; i < ON; i++) arr[i] = DW'(i * 100 - 1000);
      run_one("ramp R4", -1, -1);
      for (int i = 0; i < ON; i++) arr[i] = DW'(i * 100 - 1000);
      run_one("ramp again R5", -1, -1);
      for (int i = 0; i < ON; i++) arr[i] = (i % 2 == 0) ? DW'(777) : DW'(-1234);
      run_one("alternating R6", 100, ON * IN + 1);
      for (int i = 0; i < ON; i++) arr[i] = 12'sd2047;
      run_one("max R8", -1, -1);
      for (int i = 0; i < ON; i++) arr[i] = -12'sd2048;
      run_one("min R8", 5, ON * IN);
      run_one("min again R5", -1, -1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule